// File: doc/BRIEF.md
# Transmit FIFO Start Threshold Controller

This block decides when the transmit side may start sending the frame at the head of the transmit FIFO. The fill side gives it a running count of the bytes of the current frame already queued, and a flag that is set once the frame's last byte is in the FIFO. From these, and from a small configuration (a 2-bit threshold code, a line-rate bit and a whole-frame bit), it issues a single one-cycle start pulse to the media-side serializer.

At 100 Mb/s a frame can begin once a modest part of it is buffered. At 10 Mb/s a smaller amount is enough. When the whole-frame mode is selected, nothing starts until the frame is complete. A frame shorter than the threshold is never held back once its end is in the FIFO.

While a frame is on the wire, the block watches the FIFO. If the FIFO empties before the frame's end has been queued, the block raises an underflow event and then stays halted until it is explicitly restarted. The configuration is sampled only at frame boundaries, so a frame in flight always runs under one consistent setting.

Top module: `tx_start_gate`

## Requirements
- R1: With `rate_slow`=0, threshold codes 0, 1, 2 and 3 select 128, 256, 512 and 1024 bytes.
- R2: With `rate_slow`=1, threshold codes 0, 1, 2 and 3 select 72, 96, 128 and 160 bytes.
- R3: Outside whole-frame mode, a start requires `frame_bytes` to be strictly greater than the selected threshold. A count equal to the threshold does not start the frame.
- R4: With `whole_frame`=1, a start waits for `eof_queued`, whatever the byte count and the threshold code.
- R5: A frame whose `eof_queued` is set starts even when its byte count is below the threshold.
- R6: `start_tx` is high for exactly one cycle per frame, one clock after the start condition is seen. No further pulse follows until `ser_done` or `ser_abort` re-arms the block.
- R7: `thr_code`, `rate_slow` and `whole_frame` are sampled once, in the cycle after reset, a re-arm or a restart. A change at any other time has no effect on the current frame.
- R8: While a frame is being sent, `fifo_empty`=1 with `eof_queued`=0 gives a one-cycle `underflow` pulse. `fifo_empty` with `eof_queued`=1 gives none.
- R9: After an underflow, no start is issued until `restart` is pulsed. `ser_done` and `ser_abort` are ignored in that state.
- R10: During reset and right after it, `start_tx` and `underflow` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_bytes | input | CNT_W | Bytes of the head frame currently queued |
| eof_queued | input | 1 | Last byte of the head frame is in the FIFO |
| fifo_empty | input | 1 | Transmit FIFO holds no data |
| thr_code | input | 2 | Threshold code |
| rate_slow | input | 1 | 1 selects the 10 Mb/s threshold table |
| whole_frame | input | 1 | 1 waits for the complete frame |
| ser_done | input | 1 | Serializer finished the frame |
| ser_abort | input | 1 | Serializer abandoned the frame |
| restart | input | 1 | Leave the halted state after an underflow |
| start_tx | output | 1 | One-cycle start pulse to the serializer |
| underflow | output | 1 | One-cycle underflow event |

## Verification
The assertions check on every cycle that:
- no second start is issued inside a frame or while halted;
- a start issued without the frame's end queued had a count above the latched threshold;
- a whole-frame start always saw the end queued;
- underflow only occurs inside a frame;
- the latched configuration holds still while a frame is in flight.

Only the directed scenarios can show that each of the eight table entries is the exact value, with the boundary count not starting and one more byte starting. They also show that a short frame starts on its end, that a mid-frame configuration change is deferred to the next frame, and that restart brings the block back with the expected three-cycle latency.

// File: rtl/tx_thr_pkg.sv
package tx_thr_pkg;

    typedef enum logic [1:0] {
        PH_ARMED   = 2'd0,
        PH_SENDING = 2'd1,
        PH_HALTED  = 2'd2
    } phase_e;

    typedef struct packed {
        logic       slow;
        logic [1:0] code;
        logic       whole;
    } thr_cfg_t;

    localparam int NUM_CODES = 4;

endpackage

// File: rtl/tx_thr_cfg.sv
module tx_thr_cfg
    import tx_thr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [1:0] code_in,
    input  logic       slow_in,
    input  logic       whole_in,
    output thr_cfg_t   cfg_q
);

    thr_cfg_t cfg_d;

    always_comb begin
        cfg_d = cfg_q;
        if (load) begin
            cfg_d.slow  = slow_in;
            cfg_d.code  = code_in;
            cfg_d.whole = whole_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

endmodule

// File: rtl/tx_thr_cmp.sv
module tx_thr_cmp
    import tx_thr_pkg::*;
#(
    parameter int CNT_W     = 12,
    parameter int FAST_BASE = 128,
    parameter int SLOW_T0   = 72,
    parameter int SLOW_T1   = 96,
    parameter int SLOW_T2   = 128,
    parameter int SLOW_T3   = 160
) (
    input  thr_cfg_t         cfg,
    input  logic [CNT_W-1:0] frame_bytes,
    input  logic             eof_queued,
    output logic [CNT_W-1:0] thr_bytes,
    output logic             go
);

    localparam int SLOW_TAB [NUM_CODES] = '{SLOW_T0, SLOW_T1, SLOW_T2, SLOW_T3};

    logic [CNT_W-1:0] fast_tab [NUM_CODES];
    logic [CNT_W-1:0] slow_tab [NUM_CODES];

    // 100 Mb/s thresholds double per code step; 10 Mb/s ones come from a table
    for (genvar g = 0; g < NUM_CODES; g++) begin : g_tab
        assign fast_tab[g] = CNT_W'(FAST_BASE << g);
        assign slow_tab[g] = CNT_W'(SLOW_TAB[g]);
    end

    logic over_thr;

    always_comb begin
        thr_bytes = cfg.slow ? slow_tab[cfg.code] : fast_tab[cfg.code];
        over_thr  = frame_bytes > thr_bytes;
        if (cfg.whole) begin
            go = eof_queued;
        end else begin
            go = over_thr || eof_queued;
        end
    end

endmodule

// File: rtl/tx_thr_fsm.sv
module tx_thr_fsm
    import tx_thr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic eof_queued,
    input  logic fifo_empty,
    input  logic ser_done,
    input  logic ser_abort,
    input  logic restart,
    output logic load_cfg,
    output logic start_tx,
    output logic underflow
);

    typedef struct packed {
        phase_e phase;
        logic   reload;
        logic   start;
        logic   uflow;
    } fsm_st_t;

    fsm_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        st_d.uflow = 1'b0;
        unique case (st_q.phase)
            PH_ARMED: begin
                if (st_q.reload) begin
                    st_d.reload = 1'b0;
                end else if (go) begin
                    st_d.start = 1'b1;
                    st_d.phase = PH_SENDING;
                end
            end
            PH_SENDING: begin
                if (ser_done || ser_abort) begin
                    st_d.phase  = PH_ARMED;
                    st_d.reload = 1'b1;
                end else if (fifo_empty && !eof_queued) begin
                    st_d.uflow = 1'b1;
                    st_d.phase = PH_HALTED;
                end
            end
            PH_HALTED: begin
                if (restart) begin
                    st_d.phase  = PH_ARMED;
                    st_d.reload = 1'b1;
                end
            end
            default: begin
                st_d.phase  = PH_ARMED;
                st_d.reload = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.phase  <= PH_ARMED;
            st_q.reload <= 1'b1;
            st_q.start  <= 1'b0;
            st_q.uflow  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign load_cfg  = st_q.reload;
    assign start_tx  = st_q.start;
    assign underflow = st_q.uflow;

endmodule

// File: rtl/tx_start_gate.sv
module tx_start_gate
    import tx_thr_pkg::*;
#(
    parameter int CNT_W     = 12,
    parameter int FAST_BASE = 128,
    parameter int SLOW_T0   = 72,
    parameter int SLOW_T1   = 96,
    parameter int SLOW_T2   = 128,
    parameter int SLOW_T3   = 160
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] frame_bytes,
    input  logic             eof_queued,
    input  logic             fifo_empty,
    input  logic [1:0]       thr_code,
    input  logic             rate_slow,
    input  logic             whole_frame,
    input  logic             ser_done,
    input  logic             ser_abort,
    input  logic             restart,
    output logic             start_tx,
    output logic             underflow
);

    thr_cfg_t         cfg_q;
    logic             load_cfg;
    logic             go;
    logic [CNT_W-1:0] thr_bytes;

    tx_thr_cfg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_cfg),
        .code_in  (thr_code),
        .slow_in  (rate_slow),
        .whole_in (whole_frame),
        .cfg_q    (cfg_q)
    );

    tx_thr_cmp #(
        .CNT_W     (CNT_W),
        .FAST_BASE (FAST_BASE),
        .SLOW_T0   (SLOW_T0),
        .SLOW_T1   (SLOW_T1),
        .SLOW_T2   (SLOW_T2),
        .SLOW_T3   (SLOW_T3)
    ) u_cmp (
        .cfg         (cfg_q),
        .frame_bytes (frame_bytes),
        .eof_queued  (eof_queued),
        .thr_bytes   (thr_bytes),
        .go          (go)
    );

    tx_thr_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .eof_queued (eof_queued),
        .fifo_empty (fifo_empty),
        .ser_done   (ser_done),
        .ser_abort  (ser_abort),
        .restart    (restart),
        .load_cfg   (load_cfg),
        .start_tx   (start_tx),
        .underflow  (underflow)
    );

endmodule

// File: rtl/tx_start_gate_chk.sv
module tx_start_gate_chk
    import tx_thr_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_tx,
    input logic             underflow,
    input logic             ser_done,
    input logic             ser_abort,
    input logic             restart,
    input logic             eof_queued,
    input logic [CNT_W-1:0] frame_bytes,
    input logic [CNT_W-1:0] thr_bytes,
    input thr_cfg_t         cfg_q
);

    logic in_frame;
    logic halted;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_frame <= 1'b0;
            halted   <= 1'b0;
        end else begin
            if (start_tx) begin
                in_frame <= 1'b1;
            end else if (underflow || ser_done || ser_abort) begin
                in_frame <= 1'b0;
            end
            if (underflow) begin
                halted <= 1'b1;
            end else if (restart) begin
                halted <= 1'b0;
            end
        end
    end

    AST_ONE_START_PER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        start_tx |-> !in_frame); // R6

    AST_NO_START_WHILE_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
        start_tx |-> !halted); // R9

    AST_START_ABOVE_THRESHOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (start_tx && !$past(eof_queued)) |-> ($past(frame_bytes) > $past(thr_bytes))); // R3

    AST_WHOLE_FRAME_WAITS_EOF: assert property (@(posedge clk) disable iff (!rst_n)
        (start_tx && $past(cfg_q.whole)) |-> $past(eof_queued)); // R4

    AST_UNDERFLOW_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |-> in_frame); // R8

    AST_CFG_HELD_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (in_frame && !ser_done && !ser_abort && !start_tx) |=> $stable(cfg_q)); // R7

endmodule

bind tx_start_gate tx_start_gate_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_tx    (start_tx),
    .underflow   (underflow),
    .ser_done    (ser_done),
    .ser_abort   (ser_abort),
    .restart     (restart),
    .eof_queued  (eof_queued),
    .frame_bytes (frame_bytes),
    .thr_bytes   (thr_bytes),
    .cfg_q       (cfg_q)
);

// File: tb/tb_tx_start_gate.sv
module tb_tx_start_gate;

    localparam int CNT_W = 12;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [CNT_W-1:0] frame_bytes;
    logic             eof_queued;
    logic             fifo_empty;
    logic [1:0]       thr_code;
    logic             rate_slow;
    logic             whole_frame;
    logic             ser_done;
    logic             ser_abort;
    logic             restart;
    logic             start_tx;
    logic             underflow;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    tx_start_gate #(.CNT_W(CNT_W)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_bytes (frame_bytes),
        .eof_queued  (eof_queued),
        .fifo_empty  (fifo_empty),
        .thr_code    (thr_code),
        .rate_slow   (rate_slow),
        .whole_frame (whole_frame),
        .ser_done    (ser_done),
        .ser_abort   (ser_abort),
        .restart     (restart),
        .start_tx    (start_tx),
        .underflow   (underflow)
    );

    function automatic int exp_thr(input bit slow, input int code);
        int fast_t [4] = '{128, 256, 512, 1024};
        int slow_t [4] = '{72, 96, 128, 160};
        return slow ? slow_t[code] : fast_t[code];
    endfunction

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // end the current frame and present the configuration for the next one
    task automatic finish_frame(input bit abort, input bit slow, input int code, input bit whole);
        step();
        rate_slow   = slow;
        thr_code    = 2'(code);
        whole_frame = whole;
        ser_done    = !abort;
        ser_abort   = abort;
        step();
        ser_done    = 1'b0;
        ser_abort   = 1'b0;
        frame_bytes = '0;
        eof_queued  = 1'b0;
        fifo_empty  = 1'b0;
        step();
    endtask

    // equal count must not start, one more byte starts, then exactly one pulse
    task automatic sweep(input string req, input int thr);
        frame_bytes = CNT_W'(thr);
        for (int i = 0; i < 3; i++) begin
            step();
            check("R3", $sformatf("no start at count %0d", thr), start_tx, 1'b0);
        end
        frame_bytes = CNT_W'(thr + 1);
        step();
        check(req, $sformatf("start at count %0d", thr + 1), start_tx, 1'b1);
        for (int i = 0; i < 4; i++) begin
            step();
            check("R6", "single start pulse", start_tx, 1'b0);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        frame_bytes = '0; eof_queued = 1'b0; fifo_empty = 1'b0;
        thr_code = 2'd0; rate_slow = 1'b0; whole_frame = 1'b0;
        ser_done = 1'b0; ser_abort = 1'b0; restart = 1'b0;
        repeat (3) step();
        check("R10", "start in reset", start_tx, 1'b0);
        check("R10", "underflow in reset", underflow, 1'b0);
        rst_n = 1'b1;
        step();
        step();
        check("R10", "start after reset", start_tx, 1'b0);
        check("R10", "underflow after reset", underflow, 1'b0);
    endtask

    task automatic t_fast_table();
        for (int c = 0; c < 4; c++) begin
            sweep("R1", exp_thr(1'b0, c));
            if (c < 3) finish_frame(1'b0, 1'b0, c + 1, 1'b0);
            else       finish_frame(1'b0, 1'b1, 0, 1'b0);
        end
    endtask

    task automatic t_slow_table();
        for (int c = 0; c < 4; c++) begin
            sweep("R2", exp_thr(1'b1, c));
            if (c < 3) finish_frame(1'b0, 1'b1, c + 1, 1'b0);
            else       finish_frame(1'b0, 1'b0, 3, 1'b0);
        end
    endtask

    task automatic t_short_frame();
        frame_bytes = CNT_W'(60);
        repeat (3) begin
            step();
            check("R5", "short frame waits for end", start_tx, 1'b0);
        end
        eof_queued = 1'b1;
        step();
        check("R5", "short frame starts on end", start_tx, 1'b1);
        finish_frame(1'b1, 1'b0, 0, 1'b1);
    endtask

    task automatic t_whole_frame();
        frame_bytes = CNT_W'(1500);
        repeat (5) begin
            step();
            check("R4", "whole-frame waits despite count", start_tx, 1'b0);
        end
        eof_queued = 1'b1;
        step();
        check("R4", "whole-frame starts on end", start_tx, 1'b1);
        finish_frame(1'b0, 1'b0, 0, 1'b0);
    endtask

    task automatic t_cfg_deferred();
        thr_code  = 2'd3;
        rate_slow = 1'b1;
        step();
        frame_bytes = CNT_W'(129);
        step();
        check("R7", "latched 128 still applies", start_tx, 1'b1);
        finish_frame(1'b0, 1'b1, 3, 1'b0);
        sweep("R7", 160);
        finish_frame(1'b0, 1'b0, 0, 1'b0);
    endtask

    task automatic t_underflow();
        frame_bytes = CNT_W'(200);
        step();
        check("R1", "start for underflow case", start_tx, 1'b1);
        fifo_empty = 1'b1;
        step();
        check("R8", "underflow pulse", underflow, 1'b1);
        fifo_empty = 1'b0;
        step();
        check("R8", "underflow one cycle", underflow, 1'b0);
        eof_queued = 1'b1;
        ser_done   = 1'b1;
        step();
        ser_done   = 1'b0;
        repeat (5) begin
            step();
            check("R9", "halted ignores done and data", start_tx, 1'b0);
        end
        restart = 1'b1;
        step();
        restart = 1'b0;
        check("R9", "no start one cycle after restart", start_tx, 1'b0);
        step();
        check("R9", "no start while reloading", start_tx, 1'b0);
        step();
        check("R9", "start after restart", start_tx, 1'b1);
        fifo_empty = 1'b1;
        repeat (3) begin
            step();
            check("R8", "empty with end queued is no underflow", underflow, 1'b0);
        end
        finish_frame(1'b0, 1'b0, 0, 1'b0);
    endtask

    task automatic t_abort_rearm();
        frame_bytes = CNT_W'(300);
        step();
        check("R6", "start after abort re-arm", start_tx, 1'b1);
        finish_frame(1'b1, 1'b0, 0, 1'b0);
    endtask

    initial begin
        t_reset();
        t_fast_table();
        t_slow_table();
        t_short_frame();
        t_whole_frame();
        t_cfg_deferred();
        t_underflow();
        t_abort_rearm();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule